// File: doc/BRIEF.md
# Scatter-Gather Bus-Master DMA Engine

This block moves a disk-style channel's data between system memory and the attached device without processor involvement per word. Software builds a list of memory regions in memory. Each list entry is eight bytes: a base word followed by a count word. Software writes the list's address into a pointer register, clears the sticky flags, and sets the run bit together with the transfer direction. The engine then fetches each entry and moves one 16-bit halfword per device request. It stops when the flagged last entry is consumed, when the device reports it has finished early, when a memory access faults, or when software clears the run bit.

Memory is reached through a request/acknowledge port that holds its request until acknowledged. That port carries 32-bit entry reads and 16-bit data accesses. The device side uses a level request and a one-cycle acknowledge beat. A pair of strap inputs tells the engine whether it serves the secondary channel and whether the controller can run DMA on only one channel. The interrupt output mirrors the sticky completion flag.

Top module: `sgdma_engine`

## Requirements
- R1: After reset the command, status and pointer registers read zero (status bit 7 follows `simplex_in`), and `mem_req` and `dev_dack` are low.
- R2: Registers are selected by `reg_addr`: 0 is command, 1 is status, 2 is the list pointer (bits 1:0 read zero). An entry's base word is read at its address and its count word at address+4. The base is bit 0 forced even. The count is bits 15:0 with bit 0 ignored, and bit 31 marks the last entry. Entries sit 8 bytes apart. The address step wraps within the 4 KiB page of the pointer, so an entry at page offset 0xFF8 is followed by offset 0x000 of the same page. A memory request holds its address until acknowledged.
- R3: Writing command bit 0 from 0 to 1 starts the walk at the pointer and sets status bit 0 (active). Writing command bit 0 as 0 halts the engine at once and sets neither the error nor the interrupt flag.
- R4: Command bit 3 set means device-to-memory (memory written); clear means memory-to-device. The direction is taken at start. A command write while active leaves the running direction and the bit-3 readback unchanged.
- R5: Each beat moves one halfword with a single-cycle `dev_dack`. Successive beats within an entry use addresses stepping by 2 from the base, and data stays in list order across entries.
- R6: A count field whose even part is zero describes 65536 bytes.
- R7: When the last entry's bytes are all moved, active clears and the interrupt flag (status bit 2) sets. The error flag (status bit 1) also sets if `dev_dreq` is still high at that point.
- R8: If the device raises `dev_fin` with `dev_dreq` low while bytes remain in the current entry, the engine stops with the interrupt flag set and the error flag unchanged.
- R9: A memory access acknowledged with `mem_err` sets the error flag, clears active and leaves the interrupt flag unchanged.
- R10: Status bits 1 and 2 clear when written as one. Bits 5 and 6 are plain read/write capability flags. Bit 0 is unaffected by writes. Bit 7 reads `simplex_in`.
- R11: With both `secondary_in` and `simplex_in` high, a start write is ignored: the engine stays inactive and no flag changes.
- R12: The `irq` output always equals status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt, equals status bit 2 |
| simplex_in | input | 1 | Controller allows DMA on one channel only |
| secondary_in | input | 1 | This engine serves the secondary channel |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write |
| mem_half | output | 1 | 16-bit data access (else 32-bit entry read) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data, halfword in bits 15:0 |
| mem_rdata | input | 32 | Read data, halfword in bits 15:0 for data reads |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Bus fault, valid with `mem_ack` |
| dev_dreq | input | 1 | Device requests a beat |
| dev_fin | input | 1 | Device has finished its transfer |
| dev_dack | output | 1 | One-cycle beat acknowledge |
| dev_rdata | input | 16 | Halfword from device (device-to-memory) |
| dev_wdata | output | 16 | Halfword to device (memory-to-device) |

## Verification
The hardest situations to reach are the ones where the device's remaining demand and the list's remaining bytes disagree. That covers running out of list while the device still requests, and the device finishing exactly on an entry boundary so that a further entry is fetched before the early stop is seen. The random runs set the device's word demand to the list total plus or minus two, across one to three entries of random even length, so both mismatches and exact endings recur. Directed runs place the list at page offset 0xFF8 with a decoy entry just past the page, and hold a zero count open for 40 beats to show it is not treated as empty.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int CNT_W  = 16;

  // register selects
  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_PTR  = 2'd2;

  // bit positions software relies on
  localparam int CMD_RUN   = 0;
  localparam int CMD_TOMEM = 3;
  localparam int ST_ACT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_IRQ    = 2;
  localparam int ST_CAP0   = 5;
  localparam int ST_CAP1   = 6;
  localparam int ST_SPX    = 7;
  localparam int LAST_BIT  = 31;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH_BASE,
    S_FETCH_CNT,
    S_WAIT,
    S_DEV_IN,
    S_MEM,
    S_DEV_OUT
  } seq_state_t;

  // bytes described by a count field: bit 0 dropped, zero means the full range
  function automatic logic [CNT_W:0] region_bytes(logic [CNT_W-1:0] field);
    logic [CNT_W-1:0] even;
    even = {field[CNT_W-1:1], 1'b0};
    if (even == '0) return {1'b1, {CNT_W{1'b0}}};
    return {1'b0, even};
  endfunction

  // add inside the page that holds base; upper bits never change
  function automatic logic [ADDR_W-1:0] page_add(logic [ADDR_W-1:0] base,
                                                 logic [ADDR_W-1:0] inc,
                                                 int unsigned pbits);
    logic [ADDR_W-1:0] m;
    m = (ADDR_W'(1) << pbits) - ADDR_W'(1);
    return (base & ~m) | ((base + inc) & m);
  endfunction

endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              ev_err,
  input  logic              ev_irq,
  input  logic              simplex_in,
  input  logic              secondary_in,
  output logic [ADDR_W-1:0] tbl_base,
  output logic              start_pulse,
  output logic              start_dir,
  output logic              stop_pulse,
  output logic              irq
);

  logic              run_q, tomem_q, err_q, irq_q;
  logic [1:0]        cap_q;
  logic [ADDR_W-3:0] ptr_q;

  wire wr_cmd  = reg_wr && (reg_addr == REG_CMD);
  wire wr_stat = reg_wr && (reg_addr == REG_STAT);
  wire wr_ptr  = reg_wr && (reg_addr == REG_PTR);
  wire blocked = simplex_in && secondary_in;

  assign start_pulse = wr_cmd && reg_wdata[CMD_RUN] && !run_q && !busy && !blocked;
  assign start_dir   = reg_wdata[CMD_TOMEM];
  assign stop_pulse  = wr_cmd && !reg_wdata[CMD_RUN];
  assign tbl_base    = {ptr_q, 2'b00};
  assign irq         = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      tomem_q <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      cap_q   <= '0;
      ptr_q   <= '0;
    end else begin
      if (wr_cmd) begin
        run_q <= reg_wdata[CMD_RUN];
        if (!busy) tomem_q <= reg_wdata[CMD_TOMEM];
      end
      if (wr_ptr) ptr_q <= reg_wdata[ADDR_W-1:2];
      if (wr_stat) cap_q <= {reg_wdata[ST_CAP1], reg_wdata[ST_CAP0]};
      // a hardware event wins over a same-cycle clear
      err_q <= ev_err || (err_q && !(wr_stat && reg_wdata[ST_ERR]));
      irq_q <= ev_irq || (irq_q && !(wr_stat && reg_wdata[ST_IRQ]));
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_CMD: begin
        reg_rdata[CMD_RUN]   = run_q;
        reg_rdata[CMD_TOMEM] = tomem_q;
      end
      REG_STAT: begin
        reg_rdata[ST_ACT]  = busy;
        reg_rdata[ST_ERR]  = err_q;
        reg_rdata[ST_IRQ]  = irq_q;
        reg_rdata[ST_CAP0] = cap_q[0];
        reg_rdata[ST_CAP1] = cap_q[1];
        reg_rdata[ST_SPX]  = simplex_in;
      end
      REG_PTR: reg_rdata = tbl_base;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sgdma_seq.sv
module sgdma_seq
  import sgdma_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 12
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pulse,
  input  logic              start_dir,
  input  logic              stop_pulse,
  input  logic [ADDR_W-1:0] tbl_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_half,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic              dev_dreq,
  input  logic              dev_fin,
  output logic              dev_dack,
  input  logic [HALF_W-1:0] dev_rdata,
  output logic [HALF_W-1:0] dev_wdata,
  output logic              busy,
  output logic              ev_err,
  output logic              ev_irq,
  output logic              ev_eot_done
);

  localparam logic [ADDR_W-1:0] ENTRY_STEP = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] CNT_OFFSET = ADDR_W'(4);
  localparam logic [CNT_W:0]    BEAT_BYTES = (CNT_W+1)'(2);

  seq_state_t        st;
  logic [ADDR_W-1:0] desc_q, cur_q;
  logic [CNT_W:0]    remain_q;
  logic              last_q, tomem_q;
  logic [HALF_W-1:0] hold_q;

  wire unused_cnt_hi = ^mem_rdata[LAST_BIT-1:CNT_W];

  // named internal events
  wire bus_fault   = mem_req && mem_ack && mem_err;
  wire bus_ok      = mem_req && mem_ack && !mem_err;
  wire region_done = (st == S_WAIT) && (remain_q == '0);
  wire early_fin   = (st == S_WAIT) && (remain_q != '0) && !dev_dreq && dev_fin;

  assign ev_eot_done = region_done && last_q;
  assign ev_irq      = ev_eot_done || early_fin;
  assign ev_err      = bus_fault || (ev_eot_done && dev_dreq);

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_FETCH_BASE) || (st == S_FETCH_CNT) || (st == S_MEM);
  assign mem_half  = (st == S_MEM);
  assign mem_we    = (st == S_MEM) && tomem_q;
  assign mem_wdata = {{(WORD_W-HALF_W){1'b0}}, hold_q};
  assign dev_dack  = (st == S_DEV_IN) || (st == S_DEV_OUT);
  assign dev_wdata = hold_q;

  always_comb begin
    case (st)
      S_FETCH_BASE: mem_addr = desc_q;
      S_FETCH_CNT:  mem_addr = page_add(desc_q, CNT_OFFSET, PAGE_BITS);
      default:      mem_addr = cur_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      desc_q   <= '0;
      cur_q    <= '0;
      remain_q <= '0;
      last_q   <= 1'b0;
      tomem_q  <= 1'b0;
      hold_q   <= '0;
    end else if (stop_pulse) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (start_pulse) begin
          desc_q  <= tbl_base;
          tomem_q <= start_dir;
          st      <= S_FETCH_BASE;
        end
        S_FETCH_BASE: if (bus_fault) st <= S_IDLE;
          else if (bus_ok) begin
            cur_q <= mem_rdata & ~ADDR_W'(1);
            st    <= S_FETCH_CNT;
          end
        S_FETCH_CNT: if (bus_fault) st <= S_IDLE;
          else if (bus_ok) begin
            remain_q <= region_bytes(mem_rdata[CNT_W-1:0]);
            last_q   <= mem_rdata[LAST_BIT];
            desc_q   <= page_add(desc_q, ENTRY_STEP, PAGE_BITS);
            st       <= S_WAIT;
          end
        S_WAIT: begin
          if (region_done) st <= last_q ? S_IDLE : S_FETCH_BASE;
          else if (dev_dreq) st <= tomem_q ? S_DEV_IN : S_MEM;
          else if (early_fin) st <= S_IDLE;
        end
        S_DEV_IN: begin
          hold_q <= dev_rdata;
          st     <= S_MEM;
        end
        S_MEM: if (bus_fault) st <= S_IDLE;
          else if (bus_ok) begin
            if (tomem_q) begin
              cur_q    <= cur_q + ADDR_W'(2);
              remain_q <= remain_q - BEAT_BYTES;
              st       <= S_WAIT;
            end else begin
              hold_q <= mem_rdata[HALF_W-1:0];
              st     <= S_DEV_OUT;
            end
          end
        S_DEV_OUT: begin
          cur_q    <= cur_q + ADDR_W'(2);
          remain_q <= remain_q - BEAT_BYTES;
          st       <= S_WAIT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 12
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              simplex_in,
  input  logic              secondary_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_half,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic              dev_dreq,
  input  logic              dev_fin,
  output logic              dev_dack,
  input  logic [HALF_W-1:0] dev_rdata,
  output logic [HALF_W-1:0] dev_wdata
);

  logic              busy, ev_err, ev_irq, ev_eot_done;
  logic              start_pulse, start_dir, stop_pulse;
  logic [ADDR_W-1:0] tbl_base;

  sgdma_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .busy         (busy),
    .ev_err       (ev_err),
    .ev_irq       (ev_irq),
    .simplex_in   (simplex_in),
    .secondary_in (secondary_in),
    .tbl_base     (tbl_base),
    .start_pulse  (start_pulse),
    .start_dir    (start_dir),
    .stop_pulse   (stop_pulse),
    .irq          (irq)
  );

  sgdma_seq #(.PAGE_BITS(PAGE_BITS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_pulse (start_pulse),
    .start_dir   (start_dir),
    .stop_pulse  (stop_pulse),
    .tbl_base    (tbl_base),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_half    (mem_half),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_ack     (mem_ack),
    .mem_err     (mem_err),
    .dev_dreq    (dev_dreq),
    .dev_fin     (dev_fin),
    .dev_dack    (dev_dack),
    .dev_rdata   (dev_rdata),
    .dev_wdata   (dev_wdata),
    .busy        (busy),
    .ev_err      (ev_err),
    .ev_irq      (ev_irq),
    .ev_eot_done (ev_eot_done)
  );

endmodule

// File: rtl/sgdma_chk.sv
module sgdma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        simplex_in,
  input logic        secondary_in,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_err,
  input logic [31:0] mem_addr,
  input logic        dev_dack,
  input logic        irq,
  input logic        busy,
  input logic        ev_eot_done
);

  wire cmd_wr  = reg_wr && (reg_addr == 2'd0);
  wire stat_wr = reg_wr && (reg_addr == 2'd1);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !cmd_wr) |=> (mem_req && $stable(mem_addr)));

  // R3
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !reg_wdata[0]) |=> !busy);

  // R5
  beat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_dack |=> !dev_dack);

  // R5
  beat_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_dack |-> busy);

  // R7
  last_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_eot_done && !stat_wr) |=> (irq && !busy));

  // R9
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> !busy);

  // R11
  simplex_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && reg_wdata[0] && simplex_in && secondary_in && !busy) |=> !busy);

endmodule

bind sgdma_engine sgdma_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .simplex_in   (simplex_in),
  .secondary_in (secondary_in),
  .mem_req      (mem_req),
  .mem_ack      (mem_ack),
  .mem_err      (mem_err),
  .mem_addr     (mem_addr),
  .dev_dack     (dev_dack),
  .irq          (irq),
  .busy         (busy),
  .ev_eot_done  (ev_eot_done)
);

// File: tb/sgdma_engine_tb.sv
module sgdma_engine_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        simplex_in = 1'b0, secondary_in = 1'b0;
  logic        mem_req, mem_we, mem_half;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 32'd0;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic        dev_dreq, dev_fin, dev_dack;
  logic [15:0] dev_rdata, dev_wdata;

  sgdma_engine u_dut (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;

  // memory model: 8 KiB of halfwords, random latency, optional fault window
  logic [15:0] mem [0:4095];
  int          lat = 0;
  logic        bad_en = 1'b0;
  logic [31:0] bad_lo = 32'd0, bad_hi = 32'd0;
  logic        bd_we = 1'b0;
  logic [11:0] bd_idx = 12'd0;
  logic [15:0] bd_data = 16'd0;
  logic [11:0] m_idx, m_idx1;
  assign m_idx  = mem_addr[12:1];
  assign m_idx1 = m_idx + 12'd1;

  always @(posedge clk) begin
    if (bd_we) mem[bd_idx] <= bd_data;
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end else if (mem_req && !mem_ack) begin
      if (lat == 0) begin
        mem_ack <= 1'b1;
        lat     <= int'($urandom % 3);
        if (bad_en && mem_addr >= bad_lo && mem_addr < bad_hi) mem_err <= 1'b1;
        else begin
          mem_err <= 1'b0;
          if (mem_we) mem[m_idx] <= mem_wdata[15:0];
          mem_rdata <= mem_half ? {16'd0, mem[m_idx]} : {mem[m_idx1], mem[m_idx]};
        end
      end else lat <= lat - 1;
    end else begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end
  end

  // device model
  int          dev_idx = 0, dev_left = 0;
  logic        dev_on = 1'b0, fin_on = 1'b0, dev_clr = 1'b0, tomem_exp = 1'b0;
  logic [15:0] dseed = 16'h5a00;
  logic [15:0] cap_buf [0:511];

  function automatic logic [15:0] dpat(int k, logic [15:0] s);
    return 16'(k * 311 + 7) ^ s;
  endfunction
  function automatic logic [15:0] mpat(int a);
    return 16'(a * 5 + 32'h3c00);
  endfunction

  assign dev_dreq  = dev_on && (dev_idx < dev_left);
  assign dev_fin   = dev_on && fin_on && (dev_idx >= dev_left);
  assign dev_rdata = dpat(dev_idx, dseed);

  always @(posedge clk) begin
    if (dev_clr) dev_idx <= 0;
    else if (dev_dack) begin
      if (!tomem_exp) cap_buf[dev_idx[8:0]] <= dev_wdata;
      dev_idx <= dev_idx + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic poke(int byte_addr, logic [15:0] d);
    @(negedge clk);
    bd_idx = 12'(byte_addr >> 1); bd_data = d; bd_we = 1'b1;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      reg_read(2'd1, s);
      if (!s[0]) break;
    end
  endtask

  // list under test
  int          nd = 0;
  int          d_base [0:3];
  logic [15:0] d_len [0:3];

  function automatic int bytes_of(logic [15:0] f);
    int e = int'(f) & 32'hFFFE;
    return (e == 0) ? 65536 : e;
  endfunction
  function automatic int total_words();
    int t = 0;
    for (int j = 0; j < nd; j++) t += bytes_of(d_len[j]) / 2;
    return t;
  endfunction
  function automatic int word_addr(int k);
    int r = k;
    for (int j = 0; j < nd; j++) begin
      if (r < bytes_of(d_len[j]) / 2) return d_base[j] + 2 * r;
      r -= bytes_of(d_len[j]) / 2;
    end
    return -1;
  endfunction
  function automatic int entry_addr(int tbl, int j);
    return (tbl & ~32'hFFF) | ((tbl + 8 * j) & 32'hFFF);
  endfunction

  task automatic put_list(int tbl);
    for (int j = 0; j < nd; j++) begin
      int a = entry_addr(tbl, j);
      poke(a,     16'(d_base[j]));
      poke(a + 2, 16'(d_base[j] >> 16));
      poke(a + 4, d_len[j]);
      poke(a + 6, (j == nd - 1) ? 16'h8000 : 16'h0000);
    end
  endtask

  task automatic prefill(int words);
    int lim = total_words();
    for (int k = 0; k < lim && k <= words; k++) poke(word_addr(k), mpat(word_addr(k)));
  endtask

  task automatic launch(int tbl, logic tomem, int words, logic fin, logic mid_write);
    @(negedge clk);
    dev_clr = 1'b1;
    @(negedge clk);
    dev_clr = 1'b0;
    dev_left = words; fin_on = fin; tomem_exp = tomem; dev_on = 1'b1;
    reg_write(2'd1, 32'h0000_0006);
    reg_write(2'd2, 32'(tbl));
    reg_write(2'd0, 32'h0);
    reg_write(2'd0, {28'd0, tomem, 3'b001});
    if (mid_write) reg_write(2'd0, 32'h1);
  endtask

  task automatic check_data(string req, logic tomem, int moved);
    int miss = 0;
    for (int k = 0; k < moved; k++) begin
      if (tomem) begin
        if (mem[12'(word_addr(k) >> 1)] !== dpat(k, dseed)) miss++;
      end else if (cap_buf[k] !== mpat(word_addr(k))) miss++;
    end
    if (tomem && moved < total_words())
      if (mem[12'(word_addr(moved) >> 1)] !== mpat(word_addr(moved))) miss++;
    check(req, 32'(miss), 32'd0);
  endtask

  task automatic check_flags(string req, logic act, logic er, logic iq);
    logic [31:0] s;
    reg_read(2'd1, s);
    check(req, {29'd0, s[2:0]}, {29'd0, iq, er, act});
    check("R12 irq pin", {31'd0, irq}, {31'd0, s[2]});
  endtask

  task automatic full_run(string req, int tbl, logic tomem, int words);
    int tw;
    int moved;
    tw = total_words();
    moved = (words < tw) ? words : tw;
    put_list(tbl);
    prefill(moved);
    launch(tbl, tomem, words, 1'b1, 1'b0);
    wait_idle();
    dev_on = 1'b0;
    check_data({req, " data"}, tomem, moved);
    check_flags({req, " flags"}, 1'b0, words > tw, 1'b1);
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20250));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state, sampled while reset still held
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    check("R1 dev_dack", {31'd0, dev_dack}, 32'd0);
    rst_n = 1'b1;
    reg_read(2'd0, r); check("R1 command", r, 32'd0);
    reg_read(2'd1, r); check("R1 status", r, 32'd0);
    reg_read(2'd2, r); check("R1 pointer", r, 32'd0);

    // R10 status register access
    reg_write(2'd1, 32'h0000_0060);
    reg_read(2'd1, r); check("R10 capability bits", r, 32'h60);
    reg_write(2'd1, 32'h0000_0007);
    reg_read(2'd1, r); check("R10 w1c and active read-only", r, 32'h00);
    simplex_in = 1'b1;
    reg_read(2'd1, r); check("R10 simplex bit", r, 32'h80);

    // R11 secondary channel blocked by simplex
    secondary_in = 1'b1;
    nd = 1; d_base[0] = 32'h1800; d_len[0] = 16'd8;
    put_list(32'h0100);
    launch(32'h0100, 1'b1, 4, 1'b1, 1'b0);
    repeat (8) @(negedge clk);
    check_flags("R11 start ignored", 1'b0, 1'b0, 1'b0);
    dev_on = 1'b0; secondary_in = 1'b0; simplex_in = 1'b0;

    // R3 running then halted by software
    launch(32'h0100, 1'b1, 0, 1'b0, 1'b0);
    repeat (12) @(negedge clk);
    reg_read(2'd1, r); check("R3 active while waiting", {31'd0, r[0]}, 32'd1);
    reg_write(2'd0, 32'h0);
    check_flags("R3 halt", 1'b0, 1'b0, 1'b0);
    dev_on = 1'b0;

    // R7 exact finish, both directions
    nd = 2; d_base[0] = 32'h1800; d_len[0] = 16'd6; d_base[1] = 32'h1900; d_len[1] = 16'd10;
    full_run("R7 exact to-memory", 32'h0100, 1'b1, 8);
    full_run("R7 exact from-memory", 32'h0100, 1'b0, 8);
    // R7 list exhausted while device still requests
    full_run("R7 overrun", 32'h0100, 1'b1, 10);
    // R8 device ends early, on an entry boundary
    full_run("R8 early on boundary", 32'h0100, 1'b0, 3);

    // R2 base bit 0 and count bit 0 ignored
    nd = 1; d_base[0] = 32'h1A01; d_len[0] = 16'd9;
    put_list(32'h0200);
    d_base[0] = 32'h1A00; d_len[0] = 16'd8;
    prefill(4);
    launch(32'h0200, 1'b1, 4, 1'b1, 1'b0);
    wait_idle(); dev_on = 1'b0;
    check_data("R2 odd bits ignored", 1'b1, 4);
    check_flags("R2 odd bits flags", 1'b0, 1'b0, 1'b1);

    // R2 entry step wraps inside the page; decoy placed past the page
    poke(32'h1000, 16'h1E00); poke(32'h1002, 16'h0); poke(32'h1004, 16'd4); poke(32'h1006, 16'h8000);
    nd = 2; d_base[0] = 32'h1C00; d_len[0] = 16'd4; d_base[1] = 32'h1D00; d_len[1] = 16'd4;
    full_run("R2 page wrap", 32'h0FF8, 1'b1, 4);

    // R6 zero count is a full 64 KiB region
    nd = 1; d_base[0] = 32'h0400; d_len[0] = 16'd0;
    put_list(32'h0300);
    prefill(40);
    launch(32'h0300, 1'b1, 40, 1'b1, 1'b0);
    wait_idle(); dev_on = 1'b0;
    check_data("R6 zero count data", 1'b1, 40);
    check_flags("R6 zero count flags", 1'b0, 1'b0, 1'b1);

    // R4 direction write while active is ignored
    nd = 1; d_base[0] = 32'h1B00; d_len[0] = 16'd12; dseed = 16'h0a0a;
    put_list(32'h0100);
    prefill(6);
    launch(32'h0100, 1'b1, 6, 1'b1, 1'b1);
    wait_idle(); dev_on = 1'b0;
    check_data("R4 direction held", 1'b1, 6);
    reg_read(2'd0, r); check("R4 command readback", r, 32'h9);

    // R9 bus fault on a data access
    nd = 1; d_base[0] = 32'h1800; d_len[0] = 16'd16;
    put_list(32'h0100);
    bad_lo = 32'h1804; bad_hi = 32'h1810; bad_en = 1'b1;
    launch(32'h0100, 1'b1, 8, 1'b1, 1'b0);
    wait_idle(); dev_on = 1'b0; bad_en = 1'b0;
    check_flags("R9 fault", 1'b0, 1'b1, 1'b0);

    // R5/R7/R8 random lists and device demand
    for (int t = 0; t < 8; t++) begin
      int tw;
      int words;
      logic dir;
      nd = 1 + int'($urandom % 3);
      for (int j = 0; j < nd; j++) begin
        d_base[j] = 32'h1800 + 32'h100 * j;
        d_len[j]  = 16'(2 * (1 + $urandom % 16));
      end
      dseed = 16'($urandom);
      dir = 1'($urandom % 2);
      tw = total_words();
      words = tw + int'($urandom % 5) - 2;
      if (words < 1) words = 1;
      full_run("R5 random", 32'h0100, dir, words);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule